// File: doc/BRIEF.md
# SPI Serial Clock Prescaler

This block derives the serial clock of an SPI master from the core clock. Software writes an 8-bit prescale field. A decoder turns that field into a half-period count. A counter then toggles the serial clock each time that many core cycles have passed. Alongside the clock, the block raises one-cycle strobes that tell a shift engine when to drive the next bit and when to capture the incoming bit.

The field has two encodings, and a parameter picks one of them. The compact encoding stores a 5-bit code equal to sixteen plus half the divisor, which gives even divisors from 4 to 30. The wide encoding stores a 4-bit mantissa and a 3-bit exponent. The exponent's low bit sits at field bit 4 and its two upper bits at field bits 7:6. The divisor is the mantissa shifted left by the exponent, with a largest value of 1920. Choosing the best field for a target bit rate is left to software.

While the enable input is low, the clock rests at the idle level given by the polarity input and the counter is held at zero. Raising the enable therefore starts every frame from a known phase.

Top module: `spi_sck_prescaler`

## Requirements
- R1: Compact encoding (EXT_ENC=0): for a field low-five-bit code c from 0x12 to 0x1F, the divisor is 2*(c-16). The serial clock toggles every c-16 core cycles.
- R2: Compact encoding: a code below 0x12 acts as divisor 4. Field bits 7:5 have no effect on the period.
- R3: Wide encoding (EXT_ENC=1): the mantissa is field bits 3:0. The exponent is {field[7], field[6], field[4]}. The divisor is mantissa << exponent. Field bit 5 has no effect.
- R4: Wide encoding: a mantissa below 4 (including 0) acts as divisor 4, whatever the exponent.
- R5: Every half period of the serial clock lasts floor(divisor/2) core cycles. An odd divisor with exponent 0 rounds down, and the largest half period is 960.
- R6: While enable is low, sck_o takes the polarity input's value one cycle later and no strobe is raised. After reset, sck_o is 0 until the first clock edge.
- R7: With enable sampled high for the first time at core edge 1, the first serial clock edge occurs at core edge floor(divisor/2).
- R8: lead_o (away from idle) and trail_o (back to idle) are each one cycle long. They coincide with the sck_o change, never overlap, and never occur in consecutive cycles.
- R9: With phase input 0, sample_o accompanies the leading edge and launch_o the trailing edge. With phase input 1 the pairing is swapped. Exactly one of the two is raised with each edge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | High while a frame runs; low holds the clock idle and the counter at zero |
| prescale_i | input | 8 | Prescale field (encoding set by EXT_ENC) |
| cpol_i | input | 1 | Idle level of the serial clock |
| cpha_i | input | 1 | Phase select for launch/sample pairing |
| sck_o | output | 1 | Serial clock |
| lead_o | output | 1 | Strobe with each edge leaving the idle level |
| trail_o | output | 1 | Strobe with each edge returning to idle |
| launch_o | output | 1 | Strobe: shift engine drives the next bit |
| sample_o | output | 1 | Strobe: shift engine captures the input bit |

## Verification
The decode is exercised with fields where the mantissa is odd, even, below four and zero, so that rounding and clamping are distinguished. Exponent values light up bit 4 alone, bits 7:6 alone and all three, which separates the scattered exponent bits from a contiguous misreading. Compact codes below, at and above the lowest legal code, with junk in bits 7:5, separate clamping from masking. For each field, both the first edge after enable and the following half period are timed, which catches off-by-one counter restarts. Separate runs with each polarity and phase setting confirm idle level and strobe pairing.

// File: rtl/spi_presc_pkg.sv
package spi_presc_pkg;

    localparam int FIELD_W  = 8;
    localparam int MANT_W   = 4;
    localparam int EXP_W    = 3;
    localparam int CODE_W   = 5;
    localparam int MIN_DIV  = 4;
    localparam int MAX_DIV  = ((1 << MANT_W) - 1) << ((1 << EXP_W) - 1);
    localparam int MAX_HALF = MAX_DIV / 2;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);
    localparam int DIV_W    = CNT_W + 1;

    typedef logic [CNT_W-1:0] half_t;

    typedef struct packed {
        logic sck;
        logic lead;
        logic trail;
        logic launch;
        logic sample;
    } edge_st_t;

endpackage

// File: rtl/spi_presc_decode.sv
module spi_presc_decode
    import spi_presc_pkg::*;
#(
    parameter bit EXT_ENC = 1'b1
) (
    input  logic [FIELD_W-1:0] field_i,
    output half_t              half_o
);

    localparam half_t HALF_MIN = half_t'(MIN_DIV / 2);

    generate
        if (EXT_ENC) begin : g_wide
            logic [MANT_W-1:0] mant;
            logic [EXP_W-1:0]  expo;
            logic [DIV_W-1:0]  div;

            always_comb begin
                mant = field_i[MANT_W-1:0];
                expo = {field_i[7:6], field_i[4]};
                div  = DIV_W'(mant) << expo;
                if (mant < MANT_W'(MIN_DIV)) begin
                    half_o = HALF_MIN;
                end else begin
                    half_o = div[DIV_W-1:1];
                end
            end
        end else begin : g_compact
            logic [CODE_W-1:0] code;
            logic [CODE_W-1:0] lowest;

            always_comb begin
                code   = field_i[CODE_W-1:0];
                lowest = CODE_W'(16 + MIN_DIV / 2);
                if (code < lowest) begin
                    half_o = HALF_MIN;
                end else begin
                    half_o = half_t'(code - CODE_W'(16));
                end
            end
        end
    endgenerate

endmodule

// File: rtl/spi_presc_counter.sv
module spi_presc_counter
    import spi_presc_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  en_i,
    input  half_t half_i,
    output logic  tick_o
);

    half_t cnt_d, cnt_q;
    half_t last;

    always_comb begin
        last   = half_i - half_t'(1);
        tick_o = en_i && (cnt_q >= last);
        if (!en_i) begin
            cnt_d = '0;
        end else if (tick_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + half_t'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_presc_edge.sv
module spi_presc_edge
    import spi_presc_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  logic     en_i,
    input  logic     tick_i,
    input  logic     cpol_i,
    input  logic     cpha_i,
    output edge_st_t st_o
);

    edge_st_t st_d, st_q;
    logic     leaving;

    always_comb begin
        st_d        = st_q;
        st_d.lead   = 1'b0;
        st_d.trail  = 1'b0;
        st_d.launch = 1'b0;
        st_d.sample = 1'b0;
        leaving     = (st_q.sck == cpol_i);
        if (!en_i) begin
            st_d.sck = cpol_i;
        end else if (tick_i) begin
            st_d.sck    = ~st_q.sck;
            st_d.lead   = leaving;
            st_d.trail  = ~leaving;
            st_d.launch = cpha_i ? leaving : ~leaving;
            st_d.sample = cpha_i ? ~leaving : leaving;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/spi_sck_prescaler.sv
module spi_sck_prescaler
    import spi_presc_pkg::*;
#(
    parameter bit EXT_ENC = 1'b1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               en_i,
    input  logic [FIELD_W-1:0] prescale_i,
    input  logic               cpol_i,
    input  logic               cpha_i,
    output logic               sck_o,
    output logic               lead_o,
    output logic               trail_o,
    output logic               launch_o,
    output logic               sample_o
);

    half_t    half;
    logic     tick;
    edge_st_t st;

    spi_presc_decode #(
        .EXT_ENC (EXT_ENC)
    ) u_decode (
        .field_i (prescale_i),
        .half_o  (half)
    );

    spi_presc_counter u_counter (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .half_i (half),
        .tick_o (tick)
    );

    spi_presc_edge u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .tick_i (tick),
        .cpol_i (cpol_i),
        .cpha_i (cpha_i),
        .st_o   (st)
    );

    assign sck_o    = st.sck;
    assign lead_o   = st.lead;
    assign trail_o  = st.trail;
    assign launch_o = st.launch;
    assign sample_o = st.sample;

endmodule

// File: rtl/spi_sck_prescaler_chk.sv
module spi_sck_prescaler_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic cpol_i,
    input logic cpha_i,
    input logic sck_o,
    input logic lead_o,
    input logic trail_o,
    input logic launch_o,
    input logic sample_o
);

    // R6: idle follows polarity, no strobes
    p_idle_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (sck_o == $past(cpol_i)) && !lead_o && !trail_o);

    // R8: strobes never overlap
    p_strobe_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({lead_o, trail_o}));

    // R8: minimum divisor keeps strobes apart
    p_min_gap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lead_o || trail_o) |=> !(lead_o || trail_o));

    // R8: every clock change while running carries a strobe
    p_toggle_strobe_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(en_i) && (sck_o != $past(sck_o))) |-> (lead_o || trail_o));

    // R9: exactly one of launch/sample per edge strobe
    p_phase_onehot_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lead_o || trail_o) |-> $onehot({launch_o, sample_o}));

    // R9: leading edge samples when phase is 0
    p_phase_map_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lead_o |-> (sample_o == !$past(cpha_i)));

    // R9: leading edge leaves the idle level
    p_lead_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lead_o |-> (sck_o != $past(cpol_i)));

endmodule

bind spi_sck_prescaler spi_sck_prescaler_chk u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .cpol_i   (cpol_i),
    .cpha_i   (cpha_i),
    .sck_o    (sck_o),
    .lead_o   (lead_o),
    .trail_o  (trail_o),
    .launch_o (launch_o),
    .sample_o (sample_o)
);

// File: tb/test_spi_sck_prescaler.sv
module test_spi_sck_prescaler;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] presc = 8'h00;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;

    logic w_sck, w_lead, w_trail, w_launch, w_sample;
    logic c_sck, c_lead, c_trail, c_launch, c_sample;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    spi_sck_prescaler #(.EXT_ENC(1'b1)) i_spi_sck_prescaler (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .prescale_i(presc),
        .cpol_i(cpol), .cpha_i(cpha), .sck_o(w_sck), .lead_o(w_lead),
        .trail_o(w_trail), .launch_o(w_launch), .sample_o(w_sample));

    spi_sck_prescaler #(.EXT_ENC(1'b0)) i_spi_sck_prescaler_compact (
        .clk_i(clk), .rst_ni(rst_n), .en_i(en), .prescale_i(presc),
        .cpol_i(cpol), .cpha_i(cpha), .sck_o(c_sck), .lead_o(c_lead),
        .trail_o(c_trail), .launch_o(c_launch), .sample_o(c_sample));

    typedef struct packed {
        logic        wide;
        logic [7:0]  field;
        logic [15:0] half;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h04, 16'd2},    // R3 mantissa 4
        '{1'b1, 8'h0F, 16'd7},    // R5 odd 15 rounds down
        '{1'b1, 8'h05, 16'd2},    // R5 odd 5 rounds down
        '{1'b1, 8'h1F, 16'd15},   // R3 exponent bit at field bit 4
        '{1'b1, 8'h46, 16'd12},   // R3 exponent bit at field bit 6
        '{1'b1, 8'h86, 16'd48},   // R3 exponent bit at field bit 7
        '{1'b1, 8'hDF, 16'd960},  // R5 largest divisor
        '{1'b1, 8'h02, 16'd2},    // R4 mantissa below four
        '{1'b1, 8'hD0, 16'd2},    // R4 zero mantissa, big exponent
        '{1'b1, 8'h2A, 16'd5},    // R3 bit 5 ignored
        '{1'b1, 8'h59, 16'd36},   // R3 mixed exponent 3
        '{1'b0, 8'h12, 16'd2},    // R1 lowest legal code
        '{1'b0, 8'h1F, 16'd15},   // R1 highest code
        '{1'b0, 8'h15, 16'd5},    // R1 middle code
        '{1'b0, 8'h10, 16'd2},    // R2 clamp
        '{1'b0, 8'h00, 16'd2},    // R2 clamp zero
        '{1'b0, 8'hF8, 16'd8},    // R2 upper bits ignored
        '{1'b0, 8'h11, 16'd2}     // R2 clamp just below
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic pick(input logic wide, input logic a, input logic b);
        return wide ? a : b;
    endfunction

    // Runs one frame; reports first-edge cycle, second interval and strobes at the first edge
    task automatic run_frame(input logic wide, output int t1, output int gap,
                             output logic s_lead, output logic s_trail,
                             output logic s_launch, output logic s_sample,
                             output logic s_sck);
        logic prev;
        int   n;
        int   t2;
        t1 = -1; t2 = -1; n = 0;
        s_lead = 0; s_trail = 0; s_launch = 0; s_sample = 0; s_sck = 0;
        @(negedge clk);
        prev = pick(wide, w_sck, c_sck);
        en = 1'b1;
        while (t2 < 0 && n < 2500) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (pick(wide, w_sck, c_sck) != prev) begin
                prev = pick(wide, w_sck, c_sck);
                if (t1 < 0) begin
                    t1 = n;
                    s_sck    = prev;
                    s_lead   = pick(wide, w_lead, c_lead);
                    s_trail  = pick(wide, w_trail, c_trail);
                    s_launch = pick(wide, w_launch, c_launch);
                    s_sample = pick(wide, w_sample, c_sample);
                end else begin
                    t2 = n;
                end
            end
        end
        gap = (t2 < 0 || t1 < 0) ? -1 : t2 - t1;
        en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog (R7): actual %0d cycles expected fewer", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int   t1, gap;
        logic sl, st, sla, ssa, ssck;

        // Reset state, R6
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 reset sck", int'(w_sck), 0);
        chk("R6 reset strobes", int'(w_lead | w_trail | c_lead | c_trail), 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R6 idle high", int'(w_sck), 1);
        cpol = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R6 idle low", int'(c_sck), 0);

        // Table walk: decode and timing, R1..R5, R7, R8
        for (int i = 0; i < NV; i++) begin
            presc = VECS[i].field;
            run_frame(VECS[i].wide, t1, gap, sl, st, sla, ssa, ssck);
            chk($sformatf("R7 first edge field %02h", VECS[i].field), t1, int'(VECS[i].half));
            chk($sformatf("R5 half period field %02h", VECS[i].field), gap, int'(VECS[i].half));
            chk($sformatf("R8 lead strobe field %02h", VECS[i].field), int'(sl), 1);
        end

        // R9 pairings on the wide instance
        presc = 8'h06;
        for (int m = 0; m < 4; m++) begin
            cpol = m[1];
            cpha = m[0];
            repeat (2) @(negedge clk);
            chk($sformatf("R6 idle mode %0d", m), int'(w_sck), int'(cpol));
            run_frame(1'b1, t1, gap, sl, st, sla, ssa, ssck);
            chk($sformatf("R9 first edge level mode %0d", m), int'(ssck), int'(!cpol));
            chk($sformatf("R9 sample mode %0d", m), int'(ssa), int'(!cpha));
            chk($sformatf("R9 launch mode %0d", m), int'(sla), int'(cpha));
            chk($sformatf("R8 no trail at lead mode %0d", m), int'(st), 0);
        end

        // R6: strobes stay low and clock idles while disabled
        cpol = 1'b0;
        repeat (2) @(negedge clk);
        begin
            int seen = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                seen += int'(w_lead | w_trail | w_sck | c_sck);
            end
            chk("R6 quiet while disabled", seen, 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule